// File: doc/BRIEF.md
# Sliding-Window Majority Coincidence Trigger

This block watches a set of photodetector channels that are digitised continuously, one sample per channel on every clock of a 250 MHz domain. Each sample is compared with a shared threshold code. The pulses are negative-going, so a sample at or below the threshold counts as a crossing. A crossing keeps its channel active for a programmable number of clock cycles. A trigger is raised when enough distinct channels are active at the same time. No external trigger is needed, and a new decision is made on every cycle.

The trigger is a single-cycle pulse. It comes with a registered bit pattern of the channels that were active when the decision was taken. There is no dead time, so the pulse can repeat as soon as the active count has dipped below the majority level and risen again. The threshold, the window length and the majority level are loaded only while the block is disabled. Disabling the block also wipes all channel history.

Top module: `majority_trigger`

## Requirements
- R1: After reset, `trig` and `trig_pattern` are 0, and no trigger occurs before the block is enabled.
- R2: With the block enabled, a channel sample counts as a crossing exactly when its unsigned value is less than or equal to the loaded threshold. This holds at the range ends, code 0 and code 4095. A sample one code above the threshold is not a crossing.
- R3: A crossing sampled at clock edge k makes its channel active for exactly W cycles, where W is the loaded window length (15 to 50). The channel is active for the decisions taken at edges k+1 through k+W. A new crossing during that time restarts the W-cycle span.
- R4: `trig` is high for exactly one cycle, one clock after the edge at which the number of active channels first reaches the loaded majority level M (1 to 12). That edge is the one following the edge that sampled the deciding crossing.
- R5: While the active count stays at or above M, `trig` does not repeat. Once the count has fallen below M for at least one decision, the next rise to M fires again, with no dead time.
- R6: In the cycle `trig` is high, `trig_pattern` holds the channels that were active at that decision, with bit i for channel i. At least M of its bits are set.
- R7: `cfg_thresh`, `cfg_window` and `cfg_majority` are captured only on clock edges where `enable` is low. Changes made while `enable` is high have no effect on hits, window length or majority.
- R8: While `enable` is low, `trig` and `trig_pattern` are 0 and every channel span is cleared. Crossings seen before a disable never count after the block is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, one sample per channel per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run control; low loads the configuration and clears history |
| cfg_thresh | input | 12 | Threshold code; a sample at or below it is a crossing |
| cfg_window | input | 6 | Coincidence span in clock cycles |
| cfg_majority | input | 4 | Minimum number of active channels for a trigger |
| samples | input | 144 | Samples of all channels, channel i in bits [12*i+11 : 12*i] |
| trig | output | 1 | One-cycle trigger pulse |
| trig_pattern | output | 12 | Channels active at the decision |

## Verification
The assertions assume that the majority level is loaded as a value from 1 to 12. They also assume that the configuration inputs are meaningful only while `enable` is low. A majority of 0 would make the quorum check meaningless. The random stimulus therefore draws the window from 15 to 50 and the majority from 1 to 12, and reloads the configuration only during short disabled stretches. It also changes the configuration inputs while the block is enabled, to show that those changes have no effect. Sample values are drawn on either side of the threshold, with a hit rate that varies from phase to phase so that the active count repeatedly rises above and falls below the majority level.

// File: rtl/mct_pkg.sv
package mct_pkg;
    localparam int DEF_NCH   = 12;
    localparam int DEF_SMP_W = 12;
    localparam int DEF_WIN_W = 6;
endpackage

// File: rtl/mct_chan_timer.sv
module mct_chan_timer #(
    parameter int SMP_W = 12,
    parameter int WIN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [SMP_W-1:0] sample,
    input  logic [SMP_W-1:0] thresh,
    input  logic [WIN_W-1:0] window,
    output logic             active
);
    logic [WIN_W-1:0] span_d, span_q;
    logic             crossing;

    always_comb begin
        crossing = (sample <= thresh);
        if (!enable)
            span_d = '0;
        else if (crossing)
            span_d = window;
        else if (span_q != '0)
            span_d = span_q - 1'b1;
        else
            span_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) span_q <= '0;
        else        span_q <= span_d;
    end

    assign active = (span_q != '0);
endmodule

// File: rtl/mct_popcount.sv
module mct_popcount #(
    parameter int N    = 12,
    parameter int CNTW = 4
) (
    input  logic [N-1:0]    vec,
    output logic [CNTW-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++)
            count = count + CNTW'(vec[i]);
    end
endmodule

// File: rtl/mct_decide.sv
module mct_decide #(
    parameter int N    = 12,
    parameter int CNTW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic [N-1:0]    active,
    input  logic [CNTW-1:0] count,
    input  logic [CNTW-1:0] majority,
    output logic            trig,
    output logic [N-1:0]    pattern
);
    typedef struct packed {
        logic         met;
        logic         trig;
        logic [N-1:0] pattern;
    } dec_t;

    dec_t st_d, st_q;

    always_comb begin
        st_d.met     = enable && (count >= majority);
        st_d.trig    = st_d.met && !st_q.met;
        st_d.pattern = enable ? active : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trig    = st_q.trig;
    assign pattern = st_q.pattern;
endmodule

// File: rtl/majority_trigger.sv
module majority_trigger
    import mct_pkg::*;
#(
    parameter int NCH   = DEF_NCH,
    parameter int SMP_W = DEF_SMP_W,
    parameter int WIN_W = DEF_WIN_W,
    localparam int CNTW = $clog2(NCH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [SMP_W-1:0]     cfg_thresh,
    input  logic [WIN_W-1:0]     cfg_window,
    input  logic [CNTW-1:0]      cfg_majority,
    input  logic [NCH*SMP_W-1:0] samples,
    output logic                 trig,
    output logic [NCH-1:0]       trig_pattern
);
    typedef struct packed {
        logic [SMP_W-1:0] thresh;
        logic [WIN_W-1:0] window;
        logic [CNTW-1:0]  majority;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!enable) begin
            cfg_d.thresh   = cfg_thresh;
            cfg_d.window   = cfg_window;
            cfg_d.majority = cfg_majority;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    logic [NCH-1:0]   active;
    logic [CNTW-1:0]  active_cnt;
    logic [SMP_W-1:0] cur_thresh;
    logic [CNTW-1:0]  cur_majority;

    assign cur_thresh   = cfg_q.thresh;
    assign cur_majority = cfg_q.majority;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        mct_chan_timer #(.SMP_W(SMP_W), .WIN_W(WIN_W)) u_timer (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (enable),
            .sample (samples[g*SMP_W +: SMP_W]),
            .thresh (cfg_q.thresh),
            .window (cfg_q.window),
            .active (active[g])
        );
    end

    mct_popcount #(.N(NCH), .CNTW(CNTW)) u_count (
        .vec   (active),
        .count (active_cnt)
    );

    mct_decide #(.N(NCH), .CNTW(CNTW)) u_decide (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .active   (active),
        .count    (active_cnt),
        .majority (cfg_q.majority),
        .trig     (trig),
        .pattern  (trig_pattern)
    );
endmodule

// File: rtl/mct_checker.sv
module mct_checker #(
    parameter int NCH   = 12,
    parameter int SMP_W = 12,
    parameter int CNTW  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             trig,
    input logic [NCH-1:0]   trig_pattern,
    input logic [SMP_W-1:0] cur_thresh,
    input logic [CNTW-1:0]  cur_majority
);
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig); // R4

    AST_QUORUM_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> ($countones(trig_pattern) >= int'(cur_majority))); // R6

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable)) |-> ($stable(cur_thresh) && $stable(cur_majority))); // R7

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!trig && trig_pattern == '0)); // R8

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |-> (!trig && trig_pattern == '0)); // R1
endmodule

bind majority_trigger mct_checker #(.NCH(NCH), .SMP_W(SMP_W), .CNTW(CNTW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .trig         (trig),
    .trig_pattern (trig_pattern),
    .cur_thresh   (cur_thresh),
    .cur_majority (cur_majority)
);

// File: tb/majority_trigger_test.sv
module majority_trigger_test;
    localparam int NCH = 12;
    localparam int SW  = 12;
    localparam int WW  = 6;
    localparam int CW  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enable = 1'b0;
    logic [SW-1:0]     cfg_thresh = '0;
    logic [WW-1:0]     cfg_window = '0;
    logic [CW-1:0]     cfg_majority = '0;
    logic [NCH*SW-1:0] samples = '1;
    logic              trig;
    logic [NCH-1:0]    trig_pattern;

    always #2 clk = ~clk;

    majority_trigger uut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_thresh(cfg_thresh), .cfg_window(cfg_window), .cfg_majority(cfg_majority),
        .samples(samples), .trig(trig), .trig_pattern(trig_pattern)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int           span_m [NCH];
    bit           prev_m;
    logic [SW-1:0] thr_m;
    int           win_m, maj_m;

    function automatic logic [NCH-1:0] model_active();
        logic [NCH-1:0] a;
        for (int i = 0; i < NCH; i++) a[i] = (span_m[i] != 0);
        return a;
    endfunction

    task automatic set_smp(input int ch, input int v);
        samples[ch*SW +: SW] = SW'(v);
    endtask

    task automatic quiet_all();
        for (int i = 0; i < NCH; i++) set_smp(i, 4095);
    endtask

    task automatic step(input string tag);
        logic [NCH-1:0] act;
        bit             met, e_trig;
        logic [NCH-1:0] e_pat;
        act = model_active();
        if (!enable) begin
            e_trig = 0; e_pat = '0; prev_m = 0;
            for (int i = 0; i < NCH; i++) span_m[i] = 0;
            thr_m = cfg_thresh; win_m = int'(cfg_window); maj_m = int'(cfg_majority);
        end else begin
            met = ($countones(act) >= maj_m);
            e_trig = met && !prev_m;
            prev_m = met;
            e_pat  = act;
            for (int i = 0; i < NCH; i++) begin
                if (samples[i*SW +: SW] <= thr_m) span_m[i] = win_m;
                else if (span_m[i] != 0)          span_m[i] = span_m[i] - 1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (trig !== e_trig || trig_pattern !== e_pat) begin
            fails++;
            $display("FAIL %s: trig=%0b pattern=%03h expected trig=%0b pattern=%03h",
                     tag, trig, trig_pattern, e_trig, e_pat);
        end
    endtask

    task automatic load_cfg(input int thr, input int win, input int maj, input string tag);
        enable = 0;
        cfg_thresh = SW'(thr); cfg_window = WW'(win); cfg_majority = CW'(maj);
        quiet_all();
        step(tag);
        step(tag);
        enable = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < NCH; i++) span_m[i] = 0;
        prev_m = 0; thr_m = '0; win_m = 0; maj_m = 0;
        repeat (3) @(negedge clk);
        checks++;
        if (trig !== 1'b0 || trig_pattern !== '0) begin
            fails++;
            $display("FAIL R1: trig=%0b pattern=%03h expected trig=0 pattern=000", trig, trig_pattern);
        end
        rst_n = 1;
        for (int k = 0; k < 4; k++) step("R1");

        // R2: threshold inclusive, one code above ignored, range ends
        load_cfg(100, 15, 1, "R2");
        set_smp(3, 101); step("R2"); quiet_all(); step("R2"); step("R2");
        set_smp(3, 100); step("R2"); quiet_all();
        for (int k = 0; k < 18; k++) step("R2");
        load_cfg(0, 15, 1, "R2");
        set_smp(5, 0); step("R2"); quiet_all();
        for (int k = 0; k < 17; k++) step("R2");
        load_cfg(4095, 20, 12, "R2");
        for (int k = 0; k < 25; k++) step("R2");

        // R3: exact window end and restart
        load_cfg(1000, 15, 2, "R3");
        set_smp(0, 10); step("R3"); quiet_all();
        for (int k = 0; k < 14; k++) step("R3");
        set_smp(1, 10); step("R3"); quiet_all();
        for (int k = 0; k < 17; k++) step("R3");
        set_smp(0, 10); step("R3"); quiet_all();
        for (int k = 0; k < 13; k++) step("R3");
        set_smp(1, 10); step("R3"); quiet_all();
        for (int k = 0; k < 18; k++) step("R3");

        // R5: dip below majority by one decision then rise again
        load_cfg(1000, 15, 1, "R5");
        set_smp(2, 0); step("R5"); quiet_all();
        for (int k = 0; k < 15; k++) step("R5");
        set_smp(2, 0); step("R5"); quiet_all();
        for (int k = 0; k < 20; k++) step("R5");

        // R7 + R8: configuration changes while enabled, history wiped on disable
        load_cfg(2000, 30, 3, "R7");
        cfg_thresh = 12'd4095; cfg_window = 6'd50; cfg_majority = 4'd1;
        set_smp(0, 1500); set_smp(1, 2500); step("R7"); quiet_all();
        for (int k = 0; k < 10; k++) step("R7");
        set_smp(4, 5); set_smp(6, 5); step("R8"); quiet_all();
        enable = 0; cfg_thresh = 12'd2000; cfg_window = 6'd30; cfg_majority = 4'd1;
        step("R8"); step("R8"); enable = 1;
        for (int k = 0; k < 5; k++) step("R8");

        // R4, R6 and all: random phases
        for (int ph = 0; ph < 40; ph++) begin
            int thr = 500 + int'($urandom_range(3000));
            int p   = 1 + int'($urandom_range(7));
            load_cfg(thr, 15 + int'($urandom_range(35)), 1 + int'($urandom_range(11)), "R7");
            for (int k = 0; k < 150; k++) begin
                for (int i = 0; i < NCH; i++) begin
                    if (int'($urandom_range(99)) < p) set_smp(i, thr - int'($urandom_range(thr)));
                    else set_smp(i, thr + 1 + int'($urandom_range(4094 - thr)));
                end
                if ($urandom_range(15) == 0) begin
                    cfg_thresh = SW'($urandom); cfg_majority = CW'($urandom_range(12));
                end
                step("R4 R6 R5");
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule